// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Serial Bus

This block is the target side of a two-wire serial management bus. It serves a small file of 8-bit control registers. Every access names a starting register index. The host sends a byte count before the data on writes. On reads, the target sends the count first. SCL and SDA arrive as raw samples. The block passes them through a flop chain and detects edges and bus conditions on its own system clock. That clock must run at least 8 times faster than SCL. The block answers on SDA only through an open-drain pull-low output.

The register file is built from parameters: the number of registers, a reset value and a read-only mask for each register, the index of the byte-count register, and a short field of strap inputs. The strap field is captured while reset is held. A write to a read-only bit or a reserved bit has no effect. After each data byte moves, the register index steps forward by one. The index persists between transactions, so the usual read sequence is a write-form header carrying the index, then a repeated start and the read-form address. The live register contents are brought out as a flat vector.

Top module: `smbt_target`

## Requirements
- R1: Only the address byte 0xD2 (write form) or 0xD3 (read form) is acknowledged. After any other address byte, SDA stays released and every bit is ignored until the next start or stop.
- R2: In a write, the target acknowledges the index byte N, the count byte X and each of the first X data bytes. Those data bytes land in registers N, N+1, … in arrival order.
- R3: A data byte beyond the X announced in the count is not acknowledged and changes no register.
- R4: In a read, right after acknowledging 0xD3, the target sends the content of register 8 (the count register, writable by the host). It then sends registers from the current index upward. Each byte goes out MSB first, and the index comes from the most recent write-form header.
- R5: The target sends the next byte only while the host acknowledges. After a not-acknowledge, SDA stays released until the next start or stop.
- R6: Bits marked read-only keep their value when written. Register 7 reads 0x11 at all times. Register 1 bit 3, register 2 bits 3:1, register 4 bit 7 and register 6 bit 5 are reserved and keep their reset values.
- R7: Register 6 bits 2:0 hold the strap_in value sampled while rst_n is low, and bus writes do not change them.
- R8: A write to an index of 9 or above is acknowledged and then discarded. A read at such an index returns 0x00.
- R9: A start or stop that arrives before the ninth SCL fall of a data byte abandons the transaction without changing any register.
- R10: After reset, SDA is released and the registers read 0xFF, 0xFE, 0xFF, 0x00, 0x07, 0x00, 0x18 with the strap in bits 2:0, 0x11, and 0x09 for indices 0 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low reset; strap sampled while low |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| strap_in | input | STRAP_W | Strap levels captured into register 6 during reset |
| sda_pull_o | output | 1 | 1 pulls SDA low (open drain) |
| regs_o | output | NUM_REGS*8 | Live register contents, register i at bits i*8+7:i*8 |

## Verification
The bench builds the block with its default parameters: nine registers with the count at index 8, a 3-bit strap at index 6, and two synchronizer stages. With only nine registers, an index one step past the end is quick to reach, so both the discarded write and the zero read are covered. The strap register mixes writable, reserved and strapped bits, so a single byte written to it exercises all three kinds of masking. The SCL period is 20 system clocks. That keeps the synchronizer latency well inside each low phase, and it also leaves room to abort a byte at any bit position.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
   typedef enum logic [2:0] {
      M_IDLE, M_RX, M_ACKOUT, M_TX, M_ACKIN, M_WAIT
   } mode_e;

   typedef enum logic [1:0] {
      K_ADDR, K_INDEX, K_COUNT, K_DATA
   } kind_e;
endpackage

// File: rtl/smbt_line_sync.sv
module smbt_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_ff, sda_ff;
   logic scl_d, sda_d, scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_in};
         sda_ff <= {sda_ff[STAGES-2:0], sda_in};
         scl_d  <= scl_s;
         sda_d  <= sda_s;
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smbt_regfile.sv
module smbt_regfile #(
   parameter int NUM_REGS  = 9,
   parameter int STRAP_IDX = 6,
   parameter int STRAP_W   = 3,
   parameter logic [NUM_REGS*8-1:0] RST_VALS = '0,
   parameter logic [NUM_REGS*8-1:0] RO_MASKS = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [STRAP_W-1:0]    strap_in,
   input  logic                  wr_en,
   input  logic [7:0]            wr_idx,
   input  logic [7:0]            wr_data,
   output logic [NUM_REGS*8-1:0] q_flat
);
   localparam logic [7:0] STRAP_M = 8'((1 << STRAP_W) - 1);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [7:0] RV = RST_VALS[i*8 +: 8];
      localparam logic [7:0] RO = RO_MASKS[i*8 +: 8];
      if (RO == 8'hFF && i != STRAP_IDX) begin : g_const
         assign q_flat[i*8 +: 8] = RV;
      end else begin : g_flop
         localparam logic [7:0] SM = (i == STRAP_IDX) ? STRAP_M : 8'h00;
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= (RV & ~SM) | (8'(strap_in) & SM);
            else if (wr_en && wr_idx == 8'(i))
               q <= (wr_data & ~RO) | (q & RO);
         end
         assign q_flat[i*8 +: 8] = q;
      end
   end
endmodule

// File: rtl/smbt_engine.sv
module smbt_engine
   import smbt_pkg::*;
#(
   parameter int         NUM_REGS = 9,
   parameter int         CNT_IDX  = 8,
   parameter logic [6:0] DEV_ADDR = 7'h69,
   parameter logic [7:0] PAST_END = 8'h00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sda_s,
   input  logic                  scl_rise,
   input  logic                  scl_fall,
   input  logic                  start_det,
   input  logic                  stop_det,
   input  logic [NUM_REGS*8-1:0] q_flat,
   output logic                  wr_en,
   output logic [7:0]            wr_idx,
   output logic [7:0]            wr_data,
   output logic                  sda_pull
);
   mode_e      mode;
   kind_e      kind;
   logic       to_tx, host_ack;
   logic [7:0] shreg, idx, wr_left, rd_val, cnt_val;
   logic [3:0] bitcnt;
   logic       rx_done;

   assign cnt_val = q_flat[CNT_IDX*8 +: 8];

   always_comb begin
      rd_val = PAST_END;
      for (int i = 0; i < NUM_REGS; i++)
         if (idx == 8'(i)) rd_val = q_flat[i*8 +: 8];
   end

   assign rx_done = (mode == M_RX) && scl_fall && (bitcnt == 4'd8);
   assign wr_en   = rx_done && (kind == K_DATA) && (wr_left != 8'd0);
   assign wr_idx  = idx;
   assign wr_data = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= M_IDLE;
         kind     <= K_ADDR;
         to_tx    <= 1'b0;
         host_ack <= 1'b0;
         shreg    <= '0;
         idx      <= '0;
         wr_left  <= '0;
         bitcnt   <= '0;
         sda_pull <= 1'b0;
      end else if (stop_det) begin
         mode     <= M_IDLE;
         sda_pull <= 1'b0;
      end else if (start_det) begin
         mode     <= M_RX;
         kind     <= K_ADDR;
         bitcnt   <= '0;
         sda_pull <= 1'b0;
      end else begin
         case (mode)
            M_RX: begin
               if (scl_rise) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 4'd1;
               end else if (rx_done) begin
                  mode     <= M_ACKOUT;
                  sda_pull <= 1'b1;
                  case (kind)
                     K_ADDR: begin
                        if (shreg[7:1] != DEV_ADDR) begin
                           mode     <= M_WAIT;
                           sda_pull <= 1'b0;
                        end
                        to_tx <= shreg[0];
                        kind  <= K_INDEX;
                     end
                     K_INDEX: begin
                        idx  <= shreg;
                        kind <= K_COUNT;
                     end
                     K_COUNT: begin
                        wr_left <= shreg;
                        kind    <= K_DATA;
                     end
                     default: begin
                        if (wr_left != 8'd0) begin
                           idx     <= idx + 8'd1;
                           wr_left <= wr_left - 8'd1;
                        end else begin
                           mode     <= M_WAIT;
                           sda_pull <= 1'b0;
                        end
                     end
                  endcase
               end
            end
            M_ACKOUT: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (to_tx) begin
                     mode     <= M_TX;
                     shreg    <= cnt_val;
                     sda_pull <= ~cnt_val[7];
                  end else begin
                     mode     <= M_RX;
                     sda_pull <= 1'b0;
                  end
               end
            end
            M_TX: begin
               if (scl_fall) begin
                  bitcnt <= bitcnt + 4'd1;
                  if (bitcnt == 4'd7) begin
                     mode     <= M_ACKIN;
                     sda_pull <= 1'b0;
                  end else begin
                     shreg    <= {shreg[6:0], 1'b0};
                     sda_pull <= ~shreg[6];
                  end
               end
            end
            M_ACKIN: begin
               if (scl_rise) begin
                  host_ack <= ~sda_s;
               end else if (scl_fall) begin
                  if (host_ack) begin
                     mode     <= M_TX;
                     bitcnt   <= '0;
                     shreg    <= rd_val;
                     sda_pull <= ~rd_val[7];
                     idx      <= idx + 8'd1;
                  end else begin
                     mode <= M_WAIT;
                  end
               end
            end
            default: sda_pull <= 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/smbt_target.sv
module smbt_target #(
   parameter int         NUM_REGS    = 9,
   parameter int         CNT_IDX     = 8,
   parameter int         ID_IDX      = 7,
   parameter int         STRAP_IDX   = 6,
   parameter int         STRAP_W     = 3,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] DEV_ADDR    = 7'h69,
   parameter logic [7:0] PAST_END    = 8'h00,
   parameter logic [NUM_REGS*8-1:0] RST_VALS =
      {8'h09, 8'h11, 8'h18, 8'h00, 8'h07, 8'h00, 8'hFF, 8'hFE, 8'hFF},
   parameter logic [NUM_REGS*8-1:0] RO_MASKS =
      {8'h00, 8'hFF, 8'h27, 8'h00, 8'h80, 8'h00, 8'h0E, 8'h08, 8'h00}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_in,
   input  logic                  sda_in,
   input  logic [STRAP_W-1:0]    strap_in,
   output logic                  sda_pull_o,
   output logic [NUM_REGS*8-1:0] regs_o
);
   if (NUM_REGS < 1 || NUM_REGS > 256 || CNT_IDX >= NUM_REGS ||
       ID_IDX >= NUM_REGS || STRAP_IDX >= NUM_REGS ||
       STRAP_W < 1 || STRAP_W > 8 || SYNC_STAGES < 2) begin : g_bad_cfg
      $error("smbt_target: parameter set out of range");
   end

   logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic       wr_en;
   logic [7:0] wr_idx, wr_data;

   smbt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   smbt_regfile #(
      .NUM_REGS(NUM_REGS), .STRAP_IDX(STRAP_IDX), .STRAP_W(STRAP_W),
      .RST_VALS(RST_VALS), .RO_MASKS(RO_MASKS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .strap_in(strap_in),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .q_flat(regs_o)
   );

   smbt_engine #(
      .NUM_REGS(NUM_REGS), .CNT_IDX(CNT_IDX),
      .DEV_ADDR(DEV_ADDR), .PAST_END(PAST_END)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .q_flat(regs_o), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .sda_pull(sda_pull_o)
   );
endmodule

// File: rtl/smbt_target_chk.sv
module smbt_target_chk #(
   parameter int NUM_REGS  = 9,
   parameter int ID_IDX    = 7,
   parameter int STRAP_IDX = 6,
   parameter int STRAP_W   = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sda_pull,
   input logic                  scl_fall,
   input logic                  start_det,
   input logic                  stop_det,
   input logic                  wr_en,
   input logic [NUM_REGS*8-1:0] regs
);
   // R4 / R5: the target changes SDA only in response to a bus event
   assert_pull_on_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> $past(scl_fall || start_det || stop_det));

   // R9: a stop always leaves the line released
   assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_pull);

   // R2: every stored byte is acknowledged
   assert_write_acked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> sda_pull);

   // R6: identification register never moves
   assert_id_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(regs[ID_IDX*8 +: 8]));

   // R7: strapped bits never move after reset
   assert_strap_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(regs[STRAP_IDX*8 +: STRAP_W]));
endmodule

bind smbt_target smbt_target_chk #(
   .NUM_REGS(NUM_REGS), .ID_IDX(ID_IDX),
   .STRAP_IDX(STRAP_IDX), .STRAP_W(STRAP_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull_o),
   .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
   .wr_en(wr_en), .regs(regs_o)
);

// File: tb/smbt_target_tb.sv
`timescale 1ns/1ps
module smbt_target_tb;
   localparam int Q  = 5;
   localparam int NR = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scl = 1'b1;
   logic          sda_h = 1'b1;
   logic [2:0]    strap = 3'b101;
   logic          sda_pull;
   logic [NR*8-1:0] regs;
   logic          line;
   int            errors = 0;
   int            checks = 0;

   always #2.5 clk = ~clk;
   assign line = sda_h & ~sda_pull;

   smbt_target u_dut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(line),
      .strap_in(strap), .sda_pull_o(sda_pull), .regs_o(regs)
   );

   // {index, written byte, expected readback}
   localparam logic [23:0] VEC [8] = '{
      24'h00_5A_5A, 24'h01_00_08, 24'h02_00_0E, 24'h04_FF_7F,
      24'h06_FF_DD, 24'h07_00_11, 24'h03_A5_A5, 24'h09_33_00
   };

   task automatic chk(input logic ok, input string tag,
                      input logic [71:0] act, input logic [71:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_io(input logic b, output logic smp);
      tick(Q); sda_h = b;
      tick(Q); scl = 1'b1;
      tick(Q); smp = line;
      tick(Q); scl = 1'b0;
   endtask

   task automatic bus_start();
      if (scl) begin
         tick(Q); sda_h = 1'b0; tick(Q); scl = 1'b0;
      end else begin
         tick(Q); sda_h = 1'b1; tick(Q); scl = 1'b1;
         tick(Q); sda_h = 1'b0; tick(Q); scl = 1'b0;
      end
   endtask

   task automatic bus_stop();
      tick(Q); sda_h = 1'b0; tick(Q); scl = 1'b1;
      tick(Q); sda_h = 1'b1; tick(Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      logic s;
      for (int i = 0; i < n; i++) bit_io(b[7-i], s);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s;
      send_bits(b, 8);
      bit_io(1'b1, s);
      ack = !s;
   endtask

   task automatic recv_byte(input logic hack, output logic [7:0] d);
      logic s;
      for (int i = 0; i < 8; i++) begin
         bit_io(1'b1, s);
         d = {d[6:0], s};
      end
      bit_io(!hack, s);
   endtask

   // returns number of acknowledged bytes, stops at first not-acknowledge
   task automatic wr_txn(input logic [7:0] idx, input logic [7:0] cnt,
                         input int nb, input logic [23:0] data, output int acks);
      logic a;
      logic run;
      acks = 0; run = 1'b1;
      bus_start();
      send_byte(8'hD2, a); if (a) acks++; else run = 1'b0;
      if (run) begin send_byte(idx, a); if (a) acks++; else run = 1'b0; end
      if (run) begin send_byte(cnt, a); if (a) acks++; else run = 1'b0; end
      for (int k = 0; k < nb; k++)
         if (run) begin
            send_byte(data[23-8*k -: 8], a);
            if (a) acks++; else run = 1'b0;
         end
      bus_stop();
   endtask

   task automatic rd_txn(input logic [7:0] idx, input int nb,
                         output logic [7:0] cnt, output logic [23:0] data,
                         output int acks, output logic rel);
      logic a;
      logic [7:0] d;
      acks = 0; data = '0;
      bus_start();
      send_byte(8'hD2, a); if (a) acks++;
      send_byte(idx, a);   if (a) acks++;
      bus_start();
      send_byte(8'hD3, a); if (a) acks++;
      recv_byte(1'b1, cnt);
      for (int k = 0; k < nb; k++) begin
         recv_byte(k != nb - 1, d);
         data[23-8*k -: 8] = d;
      end
      tick(Q);
      rel = !sda_pull;
      bus_stop();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin : main
      int acks;
      logic [7:0]  cnt;
      logic [23:0] data;
      logic        rel, a;
      logic [NR*8-1:0] snap;

      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R10 / R7: reset image with strap 101 in register 6
      chk(regs == 72'h09_11_1D_00_07_00_FF_FE_FF, "R10 reset image", regs,
          72'h09_11_1D_00_07_00_FF_FE_FF);
      chk(sda_pull == 1'b0, "R10 line released", sda_pull, 0);
      chk(regs[50:48] == 3'b101, "R7 strap captured", regs[50:48], 3'b101);

      // table walk: single-byte write then indexed read back (R6, R8, R4)
      for (int v = 0; v < 8; v++) begin
         logic [7:0] vi, vw, ve;
         {vi, vw, ve} = VEC[v];
         wr_txn(vi, 8'd1, 1, {vw, 16'h0}, acks);
         chk(acks == 4, "R2/R8 write acks", acks, 4);
         rd_txn(vi, 1, cnt, data, acks, rel);
         chk(acks == 3, "R1 read header acks", acks, 3);
         chk(cnt == 8'h09, "R4 count byte", cnt, 8'h09);
         chk(data[23:16] == ve, "R6/R8 readback", data[23:16], ve);
      end
      chk(regs[50:48] == 3'b101, "R7 strap after write", regs[50:48], 3'b101);

      // R1: foreign address not acknowledged, following byte ignored
      snap = regs;
      bus_start();
      send_byte(8'hA0, a);
      chk(a == 1'b0, "R1 foreign address", a, 0);
      send_byte(8'h00, a);
      chk(a == 1'b0, "R1 ignored after miss", a, 0);
      bus_stop();
      chk(regs == snap, "R1 no change", regs, snap);

      // R2: three-byte block write from index 3
      wr_txn(8'd3, 8'd3, 3, 24'h11_22_33, acks);
      chk(acks == 6, "R2 block acks", acks, 6);
      chk(regs[47:24] == 24'h33_22_11, "R2 block stored", regs[47:24], 24'h33_22_11);

      // R3: byte beyond the count is refused
      wr_txn(8'd0, 8'd1, 2, 24'h77_88_00, acks);
      chk(acks == 4, "R3 extra byte refused", acks, 4);
      chk(regs[7:0] == 8'h77, "R3 first byte stored", regs[7:0], 8'h77);
      chk(regs[15:8] == 8'h08, "R3 extra byte dropped", regs[15:8], 8'h08);

      // R4 / R5: block read, stop driving after not-acknowledge
      rd_txn(8'd3, 2, cnt, data, acks, rel);
      chk(cnt == 8'h09, "R4 count first", cnt, 8'h09);
      chk(data[23:8] == 16'h11_22, "R4 ascending data", data[23:8], 16'h11_22);
      chk(rel == 1'b1, "R5 released after nack", rel, 1);

      // R4: count register rewritten
      wr_txn(8'd8, 8'd1, 1, 24'h02_00_00, acks);
      rd_txn(8'd4, 3, cnt, data, acks, rel);
      chk(cnt == 8'h02, "R4 new count", cnt, 8'h02);
      chk(data == 24'h22_33_DD, "R5 three-byte read", data, 24'h22_33_DD);

      // R9: stop after four data bits
      bus_start();
      send_byte(8'hD2, a); send_byte(8'd5, a); send_byte(8'd1, a);
      send_bits(8'h5C, 4);
      bus_stop();
      chk(regs[47:40] == 8'h33, "R9 stop abort", regs[47:40], 8'h33);

      // R9: repeated start after seven data bits
      bus_start();
      send_byte(8'hD2, a); send_byte(8'd5, a); send_byte(8'd1, a);
      send_bits(8'h5D, 7);
      bus_start();
      bus_stop();
      chk(regs[47:40] == 8'h33, "R9 start abort", regs[47:40], 8'h33);

      // R8: write far past the end acknowledged and discarded
      snap = regs;
      wr_txn(8'd200, 8'd1, 1, 24'hEE_00_00, acks);
      chk(acks == 4, "R8 far write acked", acks, 4);
      chk(regs == snap, "R8 far write discarded", regs, snap);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule